// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block sits beside a descriptor-driven DMA channel and decides when the channel interrupts the host. It counts finished packets and flags a completion cause after a programmable number of them. It also runs an idle-delay timer that is re-armed by every finished packet. If the timer runs out before the next packet ends, it flags a separate delay cause. That way a trickle of traffic still gets serviced, even when the packet threshold is never reached.

The surrounding register block supplies three things: the threshold, delay and enable fields of its control word, a strobe for every control write, and write-one-to-clear strobes for the status word. It reads back the pending causes and both live counters to build the status word. The three causes are:

- completion, at status bit 12;
- delay, at status bit 13;
- error, at status bit 14.

The three causes share one registered interrupt line, and each cause has its own enable. A prescaler outside the block supplies the timer's tick-enable.

Top module: `irq_coalescer`

## Requirements
- R1: After reset the pending vector `pend_o` is 000, `irq_o` is 0, the delay timer reads 0 and is stopped, and the completion counter reads the reset threshold, which is 1.
- R2: Each `pkt_done_i` pulse decrements the completion counter. When the decrement reaches zero, `pend_o[0]` (the completion cause) is set and the counter reloads from `thresh_i` in the same edge.
- R3: A `ctrl_wr_i` strobe reloads the counter from `thresh_i`. The reload overrides a packet decrement or a timer reload in the same cycle. A completion cause that the packet earns in that cycle is still set.
- R4: A `pkt_done_i` pulse with a nonzero `delay_i` loads the timer with `delay_i` and starts it, even when the timer is already running. A pulse with `delay_i` equal to 0 leaves the timer's count and run state unchanged.
- R5: A running timer decrements once per `tick_i` pulse and holds its count on cycles without a tick. When the count reaches zero, the timer stops, `pend_o[1]` (the delay cause) is set, and the counter reloads from `thresh_i`, unless a packet or a control write acts on the counter in that cycle. A stopped timer ignores ticks.
- R6: A `fault_i` pulse sets `pend_o[2]` (the error cause).
- R7: When `clr_wr_i` is high, each bit of `pend_o` whose `clr_mask_i` bit is 1 is cleared, and bits whose mask bit is 0 are kept. A cause that is set in the same cycle stays set.
- R8: `irq_o` is a register that is loaded each cycle with the OR over the three causes of `pend_o` AND `irq_en_i`. It follows a change in the pending bits or the enables one cycle later.
- R9: With a threshold of 0, the counter reloads to 0. The next packet wraps it to all ones (255 for 8 bits) and does not set the completion cause.
- R10: `tmr_o` presents the low 8 bits of the delay timer count, zero-extended when the timer is narrower than 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_done_i | input | 1 | One-cycle pulse for each completed packet |
| tick_i | input | 1 | Prescaled timer tick-enable |
| ctrl_wr_i | input | 1 | Control register write strobe |
| thresh_i | input | CNT_W | Completion threshold field |
| delay_i | input | DLY_W | Idle-delay reload field |
| irq_en_i | input | 3 | Per-cause interrupt enables |
| fault_i | input | 1 | Error event pulse |
| clr_wr_i | input | 1 | Status write strobe |
| clr_mask_i | input | 3 | Write-one-to-clear data for the causes |
| pend_o | output | 3 | Pending causes: [0] completion, [1] delay, [2] error |
| cnt_o | output | CNT_W | Live completion counter |
| tmr_o | output | 8 | Low 8 bits of the delay timer |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The bench uses the default widths: an 8-bit counter, an 8-bit delay timer and a reset threshold of 1. With these widths, the wrap of a zero threshold to 255 is visible in a single packet, and a one-cycle mistake in when the timer expires shows up as a wrong count in the status byte.

Small delays of three ticks bring these cases within a few dozen cycles:
- a timer re-armed in mid-count;
- a packet with zero delay landing on a running timer;
- a timer reload that picks up a threshold changed without a control write.

The bench also drives same-cycle collisions on purpose:
- packet together with control write;
- set together with clear;
- tick together with clear.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
  localparam int unsigned NCAUSE = 3;
  typedef enum int unsigned {
    CAUSE_DONE = 0,
    CAUSE_DLY  = 1,
    CAUSE_ERR  = 2
  } cause_e;
endpackage

// File: rtl/done_counter.sv
module done_counter #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_i,
  input  logic             reload_i,
  input  logic             expire_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, dec;

  assign dec = cnt_q - CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    hit_o = 1'b0;
    if (pkt_i) begin
      if (dec == '0) begin
        hit_o = 1'b1;
        cnt_d = thresh_i;
      end else begin
        cnt_d = dec;
      end
    end else if (expire_i) begin
      cnt_d = thresh_i;
    end
    // control write has the last word on the counter value
    if (reload_i) cnt_d = thresh_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_W'(RST_VAL);
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dly_timer.sv
module dly_timer #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic [DLY_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [DLY_W-1:0] cnt_q;
  logic             run_q;
  logic             arm;

  assign arm      = pkt_i && (delay_i != '0);
  assign expire_o = run_q && tick_i && (cnt_q == DLY_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (arm) begin
      cnt_q <= delay_i;
      run_q <= 1'b1;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - DLY_W'(1);
      if (cnt_q == DLY_W'(1)) run_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pend_irq.sv
module pend_irq #(
  parameter int unsigned NCAUSE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCAUSE-1:0] set_i,
  input  logic [NCAUSE-1:0] clr_i,
  input  logic [NCAUSE-1:0] en_i,
  output logic [NCAUSE-1:0] pend_o,
  output logic              irq_o
);
  logic [NCAUSE-1:0] pend_q;
  logic              irq_q;

  for (genvar k = 0; k < NCAUSE; k++) begin : g_cause
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[k] <= 1'b0;
      else         pend_q[k] <= set_i[k] | (pend_q[k] & ~clr_i[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend_q & en_i);
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
  import irq_coal_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned DLY_W   = 8,
  parameter int unsigned CNT_RST = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_done_i,
  input  logic              tick_i,
  input  logic              ctrl_wr_i,
  input  logic [CNT_W-1:0]  thresh_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic [NCAUSE-1:0] irq_en_i,
  input  logic              fault_i,
  input  logic              clr_wr_i,
  input  logic [NCAUSE-1:0] clr_mask_i,
  output logic [NCAUSE-1:0] pend_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [7:0]        tmr_o,
  output logic              irq_o
);
  localparam int unsigned TMR_OUT_W = 8;

  logic              hit, expire;
  logic [DLY_W-1:0]  tmr;
  logic [NCAUSE-1:0] set_vec, clr_vec;

  done_counter #(.CNT_W(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pkt_i    (pkt_done_i),
    .reload_i (ctrl_wr_i),
    .expire_i (expire),
    .thresh_i (thresh_i),
    .cnt_o    (cnt_o),
    .hit_o    (hit)
  );

  dly_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pkt_i    (pkt_done_i),
    .tick_i   (tick_i),
    .delay_i  (delay_i),
    .cnt_o    (tmr),
    .expire_o (expire)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[CAUSE_DONE] = hit;
    set_vec[CAUSE_DLY]  = expire;
    set_vec[CAUSE_ERR]  = fault_i;
  end

  assign clr_vec = clr_wr_i ? clr_mask_i : '0;

  pend_irq #(.NCAUSE(NCAUSE)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .en_i   (irq_en_i),
    .pend_o (pend_o),
    .irq_o  (irq_o)
  );

  if (DLY_W >= TMR_OUT_W) begin : g_tmr_trunc
    assign tmr_o = tmr[TMR_OUT_W-1:0];
  end else begin : g_tmr_ext
    assign tmr_o = {{(TMR_OUT_W-DLY_W){1'b0}}, tmr};
  end
endmodule

// File: rtl/irq_coalescer_chk.sv
module irq_coalescer_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DLY_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pkt_done_i,
  input logic             tick_i,
  input logic             ctrl_wr_i,
  input logic [CNT_W-1:0] thresh_i,
  input logic [2:0]       irq_en_i,
  input logic             fault_i,
  input logic             clr_wr_i,
  input logic [2:0]       clr_mask_i,
  input logic [2:0]       pend_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic [7:0]       tmr_o,
  input logic             irq_o
);
  // R2
  done_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_done_i && cnt_o == CNT_W'(1)) |=> pend_o[0]);

  // R2
  done_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_done_i && !ctrl_wr_i && cnt_o != CNT_W'(1)) |=> cnt_o == CNT_W'($past(cnt_o) - CNT_W'(1)));

  // R3
  ctrl_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> cnt_o == $past(thresh_i));

  // R5
  tmr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pkt_done_i && !tick_i) |=> $stable(tmr_o));

  // R6
  fault_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> pend_o[2]);

  // R7
  pend_keep0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o[0] && !(clr_wr_i && clr_mask_i[0])) |=> pend_o[0]);
  // R7
  pend_keep1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o[1] && !(clr_wr_i && clr_mask_i[1])) |=> pend_o[1]);
  // R7
  pend_keep2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o[2] && !(clr_wr_i && clr_mask_i[2])) |=> pend_o[2]);

  // R8
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_o & irq_en_i)) |=> irq_o);
  // R8
  irq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(pend_o & irq_en_i)) |=> !irq_o);
endmodule

bind irq_coalescer irq_coalescer_chk #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pkt_done_i (pkt_done_i),
  .tick_i     (tick_i),
  .ctrl_wr_i  (ctrl_wr_i),
  .thresh_i   (thresh_i),
  .irq_en_i   (irq_en_i),
  .fault_i    (fault_i),
  .clr_wr_i   (clr_wr_i),
  .clr_mask_i (clr_mask_i),
  .pend_o     (pend_o),
  .cnt_o      (cnt_o),
  .tmr_o      (tmr_o),
  .irq_o      (irq_o)
);

// File: tb/irq_coalescer_test.sv
module irq_coalescer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pkt_done_i = 1'b0, tick_i = 1'b0, ctrl_wr_i = 1'b0;
  logic [7:0] thresh_i = 8'd1, delay_i = 8'd0;
  logic [2:0] irq_en_i = 3'b000, clr_mask_i = 3'b000;
  logic       fault_i = 1'b0, clr_wr_i = 1'b0;
  logic [2:0] pend_o;
  logic [7:0] cnt_o, tmr_o;
  logic       irq_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] pend;
    logic [7:0] cnt;
    logic [7:0] tmr;
    logic       irq;
    string      req;
  } item_t;
  item_t exp_q[$];

  always #4 clk_i = ~clk_i;

  irq_coalescer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pkt_done_i(pkt_done_i), .tick_i(tick_i),
    .ctrl_wr_i(ctrl_wr_i), .thresh_i(thresh_i), .delay_i(delay_i),
    .irq_en_i(irq_en_i), .fault_i(fault_i), .clr_wr_i(clr_wr_i),
    .clr_mask_i(clr_mask_i), .pend_o(pend_o), .cnt_o(cnt_o), .tmr_o(tmr_o),
    .irq_o(irq_o)
  );

  task automatic compare(input item_t e);
    tests++;
    if (pend_o !== e.pend || cnt_o !== e.cnt || tmr_o !== e.tmr || irq_o !== e.irq) begin
      fails++;
      $display("FAIL %s: pend=%b cnt=%0d tmr=%0d irq=%b, expected pend=%b cnt=%0d tmr=%0d irq=%b",
               e.req, pend_o, cnt_o, tmr_o, irq_o, e.pend, e.cnt, e.tmr, e.irq);
    end
  endtask

  // monitor: results of an edge are sampled 2 ns after it
  initial forever begin
    @(posedge clk_i);
    #2;
    if (exp_q.size() > 0) compare(exp_q.pop_front());
  end

  // driver: called at a falling edge, applies one cycle of stimulus
  task automatic cyc(input logic pkt, input logic tk, input logic cw, input logic flt,
                     input logic cl, input logic [2:0] msk,
                     input logic [2:0] ep, input logic [7:0] ec, input logic [7:0] et,
                     input logic ei, input string r);
    item_t it;
    pkt_done_i = pkt; tick_i = tk; ctrl_wr_i = cw; fault_i = flt;
    clr_wr_i = cl; clr_mask_i = msk;
    it.pend = ep; it.cnt = ec; it.tmr = et; it.irq = ei; it.req = r;
    exp_q.push_back(it);
    @(negedge clk_i);
  endtask

  initial begin
    #100000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    tests++;
    if (pend_o !== 3'b000 || irq_o !== 1'b0 || cnt_o !== 8'd1 || tmr_o !== 8'd0) begin
      fails++;
      $display("FAIL R1: pend=%b irq=%b cnt=%0d tmr=%0d, expected 000 0 1 0",
               pend_o, irq_o, cnt_o, tmr_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    //    pkt tk cw flt cl msk     pend    cnt tmr irq
    cyc(0,0,0,0,0,3'b000, 3'b000, 1, 0, 0, "R1 idle after reset");
    cyc(1,0,0,0,0,3'b000, 3'b001, 1, 0, 0, "R2 threshold 1 hit");
    irq_en_i = 3'b001;
    cyc(0,0,0,0,0,3'b000, 3'b001, 1, 0, 1, "R8 enable raises irq");
    cyc(0,0,0,0,1,3'b001, 3'b000, 1, 0, 1, "R7 clear completion");
    cyc(0,0,0,0,0,3'b000, 3'b000, 1, 0, 0, "R8 irq drops");
    thresh_i = 8'd3;
    cyc(0,0,1,0,0,3'b000, 3'b000, 3, 0, 0, "R3 control write reload");
    cyc(1,0,0,0,0,3'b000, 3'b000, 2, 0, 0, "R2 decrement");
    cyc(1,0,0,0,0,3'b000, 3'b000, 1, 0, 0, "R2 decrement");
    cyc(1,0,0,0,0,3'b000, 3'b001, 3, 0, 0, "R2 hit and reload");
    cyc(0,0,0,0,0,3'b000, 3'b001, 3, 0, 1, "R8 one-cycle lag");
    cyc(0,0,0,0,1,3'b110, 3'b001, 3, 0, 1, "R7 mask zero keeps bit");
    cyc(0,0,0,0,1,3'b001, 3'b000, 3, 0, 1, "R7 clear");
    cyc(0,0,0,0,0,3'b000, 3'b000, 3, 0, 0, "R8 irq drops");
    delay_i = 8'd3; irq_en_i = 3'b010;
    cyc(1,0,0,0,0,3'b000, 3'b000, 2, 3, 0, "R4 arm timer");
    cyc(0,1,0,0,0,3'b000, 3'b000, 2, 2, 0, "R5 tick");
    cyc(0,0,0,0,0,3'b000, 3'b000, 2, 2, 0, "R5 hold without tick");
    cyc(0,1,0,0,0,3'b000, 3'b000, 2, 1, 0, "R5 tick");
    cyc(0,1,0,0,0,3'b000, 3'b010, 3, 0, 0, "R5 expiry sets delay cause and reloads");
    cyc(0,0,0,0,0,3'b000, 3'b010, 3, 0, 1, "R8 delay irq");
    cyc(0,1,0,0,1,3'b010, 3'b000, 3, 0, 1, "R5 stopped timer ignores tick");
    cyc(0,0,0,0,0,3'b000, 3'b000, 3, 0, 0, "R10 timer readback");
    cyc(1,0,0,0,0,3'b000, 3'b000, 2, 3, 0, "R4 rearm");
    cyc(0,1,0,0,0,3'b000, 3'b000, 2, 2, 0, "R5 tick");
    cyc(1,0,0,0,0,3'b000, 3'b000, 1, 3, 0, "R4 retrigger mid-count");
    delay_i = 8'd0;
    cyc(1,0,0,0,0,3'b000, 3'b001, 3, 3, 0, "R4 zero delay leaves timer");
    cyc(0,1,0,0,0,3'b000, 3'b001, 3, 2, 0, "R4 timer still running");
    cyc(0,1,0,0,0,3'b000, 3'b001, 3, 1, 0, "R5 tick");
    thresh_i = 8'd5;
    cyc(0,1,0,0,0,3'b000, 3'b011, 5, 0, 0, "R5 expiry reloads new threshold");
    cyc(0,0,0,0,0,3'b000, 3'b011, 5, 0, 1, "R8 masked completion, delay enabled");
    cyc(0,0,0,0,1,3'b011, 3'b000, 5, 0, 1, "R7 clear two bits");
    irq_en_i = 3'b111; thresh_i = 8'd2;
    cyc(1,0,1,0,0,3'b000, 3'b000, 2, 0, 0, "R3 control write beats packet");
    cyc(1,0,0,0,0,3'b000, 3'b000, 1, 0, 0, "R2 decrement");
    thresh_i = 8'd4;
    cyc(1,0,1,0,0,3'b000, 3'b001, 4, 0, 0, "R3 hit kept with control write");
    cyc(0,0,0,1,1,3'b100, 3'b101, 4, 0, 1, "R6 fault set beats clear");
    cyc(0,0,0,0,1,3'b101, 3'b000, 4, 0, 1, "R7 clear");
    cyc(0,0,0,0,0,3'b000, 3'b000, 4, 0, 0, "R8 irq drops");
    thresh_i = 8'd0;
    cyc(0,0,1,0,0,3'b000, 3'b000, 0, 0, 0, "R9 zero threshold");
    cyc(1,0,0,0,0,3'b000, 3'b000, 255, 0, 0, "R9 wrap without cause");
    cyc(0,0,0,0,0,3'b000, 3'b000, 255, 0, 0, "R9 no irq");
    cyc(0,0,0,0,0,3'b000, 3'b000, 255, 0, 0, "R9 settled");
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule